// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block runs single conversions on an external 12-bit successive-approximation converter that has a three-wire serial port. It drives the converter's active-low select line and its serial clock, and it reads the converter's data line. A one-cycle start request in the idle state pulls the select line low, which begins a conversion. The controller then keeps the serial clock low until the conversion ends. It detects the end in one of two ways: it sees the data line rise, or the maximum conversion time runs out.

The controller then produces 13 serial clock periods in mode 0. The clock idles low, the converter changes its data on falling edges and the controller samples on rising edges. The first bit sampled is a marker that must be 1, and the twelve result bits follow it, most significant first. After the 13th falling edge the controller raises the select line and shows the word for one cycle with a valid strobe. It then holds the select line high for a recovery interval. An abort request during the conversion raises the select line at once and discards the frame. A longer acquisition interval then applies before the next conversion. All intervals are counted in system clock cycles and set by parameters.

States: IDLE (select high, waiting for start), CONVERT (select low, clock low), CLK_LOW and CLK_HIGH (the two halves of one serial clock period), TAIL (low half after the 13th falling edge), RECOVER (select high, interval running). Transitions: IDLE to CONVERT on start; CONVERT to CLK_LOW on a data-line rise or on timeout; CONVERT to RECOVER on abort; CLK_LOW to CLK_HIGH after a half period, which is where the sample is taken; CLK_HIGH to CLK_LOW after a half period while fewer than 13 bits have been taken, otherwise CLK_HIGH to TAIL; TAIL to RECOVER after a half period, with the valid strobe; RECOVER to IDLE when its interval expires.

Top module: `sar_read_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1 and sclk_o, busy_o, valid_o, aborted_o and marker_err_o are all 0.
- R2: A start_i pulse while busy_o is 0 pulls cs_n_o low. A start_i pulse while busy_o is 1 has no effect and produces no extra frame.
- R3: sclk_o is 0 whenever cs_n_o is 1, and it stays 0 during the conversion until the end of conversion is detected.
- R4: The end of conversion is a 0-to-1 transition of dout_i seen while cs_n_o is low. A level of 1 that is left over from before the frame is not taken as the end, and the first rising edge of sclk_o comes only after the converter raises dout_i.
- R5: If dout_i never rises, the readout begins after TIMEOUT_CYCLES system cycles (default 2125, i.e. 8.5 µs at 250 MHz) counted from the fall of cs_n_o.
- R6: A completed frame has exactly 13 rising edges of sclk_o. Each half period lasts HALF_CYCLES system cycles (default 50, which gives 2.5 MHz at 250 MHz).
- R7: The bit sampled at the first rising edge is the marker, and the next 12 bits form result_o with the first of them at bit 11. valid_o is high for one cycle, in the same cycle that cs_n_o rises, and result_o holds the word from then on.
- R8: marker_err_o is updated together with valid_o. It is 1 if the marker bit was 0 and 0 if the marker bit was 1.
- R9: After a completed frame, cs_n_o stays high for at least RECOVER_CYCLES cycles before it falls again.
- R10: abort_i during the conversion raises cs_n_o within one cycle, produces no sclk_o edges and no valid_o, and sets aborted_o. cs_n_o then stays high for at least ACQ_CYCLES cycles, and aborted_o clears with the next valid_o.
- R11: abort_i during the readout is ignored: the frame completes with a correct result and aborted_o stays 0.
- R12: busy_o is 1 from the cycle after an accepted start until the recovery interval ends, and it is 1 whenever cs_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in IDLE |
| abort_i | input | 1 | Abort request, honoured only during the conversion |
| dout_i | input | 1 | Serial data from the converter (asynchronous) |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| result_o | output | 12 | Last completed conversion word |
| valid_o | output | 1 | One-cycle strobe when result_o is updated |
| busy_o | output | 1 | Frame or recovery interval in progress |
| aborted_o | output | 1 | The last conversion was aborted |
| marker_err_o | output | 1 | The last frame's marker bit was 0 |

## Verification
The assertions assume that start_i and abort_i are synchronous to clk. They also assume that dout_i changes at least three cycles before the next rising edge of sclk_o, so that the value passed through the synchroniser is settled when it is sampled. The bench's converter model drives dout_i on clk edges. It changes dout_i one cycle after it sees a falling edge of sclk_o, which leaves almost a whole half period of margin. Start and abort are driven on falling clk edges and last exactly one cycle, except where a test holds start high to measure an interval. The model drives dout_i high while the select line is high, so every frame begins with a stale 1 on the line.

// File: rtl/sar_read_pkg.sv
package sar_read_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_TAIL,
        ST_RECOVER
    } sar_state_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_interval_timer.sv
module sar_interval_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sar_capture_shift.sv
module sar_capture_shift #(
    parameter int FRAME_BITS = 13,
    parameter int CNT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  sample_i,
    input  logic                  bit_i,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic [CNT_W-1:0]      count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_o <= '0;
            count_o <= '0;
        end else if (clear_i) begin
            frame_o <= '0;
            count_o <= '0;
        end else if (sample_i) begin
            frame_o <= {frame_o[FRAME_BITS-2:0], bit_i};
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl
    import sar_read_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int HALF_CYCLES    = 50,
    parameter int TIMEOUT_CYCLES = 2125,
    parameter int RECOVER_CYCLES = 125,
    parameter int ACQ_CYCLES     = 375
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              dout_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              busy_o,
    output logic              aborted_o,
    output logic              marker_err_o
);
    localparam int FRAME_BITS = DATA_W + 1;
    localparam int MAX_A      = (TIMEOUT_CYCLES > ACQ_CYCLES) ? TIMEOUT_CYCLES : ACQ_CYCLES;
    localparam int MAX_B      = (RECOVER_CYCLES > HALF_CYCLES) ? RECOVER_CYCLES : HALF_CYCLES;
    localparam int TMR_MAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int BIT_W      = $clog2(FRAME_BITS + 1);

    sar_state_e state_q, state_nxt;

    logic                  dout_s, dout_prev_q, dout_rise;
    logic                  tmr_load, tmr_done;
    logic [TMR_W-1:0]      tmr_val;
    logic                  abort_path;
    logic                  cap_clear, cap_sample;
    logic [FRAME_BITS-1:0] frame;
    logic [BIT_W-1:0]      bit_cnt;
    logic                  frame_done;

    sar_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dout_i),
        .q_o   (dout_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_prev_q <= 1'b1;
        end else begin
            dout_prev_q <= dout_s;
        end
    end

    assign dout_rise = dout_s & ~dout_prev_q;

    sar_interval_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    sar_capture_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(BIT_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cap_clear),
        .sample_i (cap_sample),
        .bit_i    (dout_s),
        .frame_o  (frame),
        .count_o  (bit_cnt)
    );

    assign frame_done = (bit_cnt == BIT_W'(FRAME_BITS));

    // next-state logic
    always_comb begin
        state_nxt  = state_q;
        abort_path = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_nxt = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (abort_i) begin
                    state_nxt  = ST_RECOVER;
                    abort_path = 1'b1;
                end else if (dout_rise || tmr_done) begin
                    state_nxt = ST_CLK_LOW;
                end
            end
            ST_CLK_LOW: begin
                if (tmr_done) state_nxt = ST_CLK_HIGH;
            end
            ST_CLK_HIGH: begin
                if (tmr_done) state_nxt = frame_done ? ST_TAIL : ST_CLK_LOW;
            end
            ST_TAIL: begin
                if (tmr_done) state_nxt = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (tmr_done) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // interval selection per entered state
    always_comb begin
        tmr_load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_CONVERT:  tmr_val = TMR_W'(TIMEOUT_CYCLES - 1);
            ST_CLK_LOW,
            ST_CLK_HIGH,
            ST_TAIL:     tmr_val = TMR_W'(HALF_CYCLES - 1);
            ST_RECOVER:  tmr_val = abort_path ? TMR_W'(ACQ_CYCLES - 1)
                                              : TMR_W'(RECOVER_CYCLES - 1);
            default:     tmr_val = '0;
        endcase
    end

    assign cap_clear  = (state_nxt == ST_CONVERT) && (state_q != ST_CONVERT);
    assign cap_sample = (state_q == ST_CLK_LOW) && (state_nxt == ST_CLK_HIGH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o       <= 1'b1;
            sclk_o       <= 1'b0;
            busy_o       <= 1'b0;
            valid_o      <= 1'b0;
            result_o     <= '0;
            aborted_o    <= 1'b0;
            marker_err_o <= 1'b0;
        end else begin
            cs_n_o  <= (state_nxt == ST_IDLE) || (state_nxt == ST_RECOVER);
            sclk_o  <= (state_nxt == ST_CLK_HIGH);
            busy_o  <= (state_nxt != ST_IDLE);
            valid_o <= 1'b0;
            if ((state_q == ST_TAIL) && (state_nxt == ST_RECOVER)) begin
                valid_o      <= 1'b1;
                result_o     <= frame[DATA_W-1:0];
                marker_err_o <= ~frame[FRAME_BITS-1];
                aborted_o    <= 1'b0;
            end
            if (abort_path) begin
                aborted_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_read_ctrl_chk.sv
module sar_read_ctrl_chk #(
    parameter int MIN_HIGH = 125
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic valid_o,
    input logic busy_o,
    input logic aborted_o
);
    int  hi_run;
    logic seen_close;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run     <= 0;
            seen_close <= 1'b0;
        end else begin
            if (cs_n_o && !seen_close) begin
                hi_run <= 0;
            end else if (cs_n_o && hi_run < MIN_HIGH + 2) begin
                hi_run <= hi_run + 1;
            end else if (!cs_n_o) begin
                hi_run <= 0;
            end
            if (valid_o || aborted_o) seen_close <= 1'b1;
        end
    end

    assert_sclk_low_when_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    assert_clock_low_after_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |=> !sclk_o);

    assert_valid_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_with_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(cs_n_o));

    assert_busy_while_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    assert_abort_closes_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted_o) |-> ($rose(cs_n_o) && !valid_o));

    assert_min_deselect_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && seen_close) |-> (hi_run >= MIN_HIGH));
endmodule

bind sar_read_ctrl sar_read_ctrl_chk #(.MIN_HIGH(RECOVER_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .busy_o    (busy_o),
    .aborted_o (aborted_o)
);

// File: tb/sar_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_read_ctrl_tb_top;
    localparam int DATA_W   = 12;
    localparam int HALF     = 50;
    localparam int TIMEOUT  = 2125;
    localparam int RECOVER  = 125;
    localparam int ACQ      = 375;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic abort_i = 1'b0;
    logic dout_m = 1'b1;
    logic cs_n_o, sclk_o, valid_o, busy_o, aborted_o, marker_err_o;
    logic [DATA_W-1:0] result_o;

    always #2 clk = ~clk;

    sar_read_ctrl #(
        .DATA_W(DATA_W), .HALF_CYCLES(HALF), .TIMEOUT_CYCLES(TIMEOUT),
        .RECOVER_CYCLES(RECOVER), .ACQ_CYCLES(ACQ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .dout_i(dout_m), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o),
        .valid_o(valid_o), .busy_o(busy_o), .aborted_o(aborted_o),
        .marker_err_o(marker_err_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // converter model and monitor
    logic [11:0] m_word = '0;
    int  m_delay = 100;
    int  eoc_cnt = 0;
    int  bit_idx = 0;
    int  rises = 0;
    int  lat_cnt = 0;
    int  first_lat = 0;
    bit  measuring = 0;
    int  hi_cnt = 0;
    int  last_hi = 0;
    int  frames = 0;
    int  valids = 0;
    logic prev_cs = 1'b1;
    logic prev_sclk = 1'b0;
    int  cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_cs   <= cs_n_o;
        prev_sclk <= sclk_o;
        if (valid_o) valids <= valids + 1;
        if (prev_cs && !cs_n_o) begin
            dout_m    <= 1'b0;
            eoc_cnt   <= m_delay;
            bit_idx   <= 0;
            rises     <= 0;
            lat_cnt   <= 1;
            measuring <= 1;
            last_hi   <= hi_cnt;
            frames    <= frames + 1;
        end else if (!cs_n_o) begin
            lat_cnt <= lat_cnt + 1;
            if (eoc_cnt > 0) begin
                eoc_cnt <= eoc_cnt - 1;
                if (eoc_cnt == 1) dout_m <= 1'b1;
            end
            if (!prev_sclk && sclk_o) begin
                rises <= rises + 1;
                if (measuring) begin
                    first_lat <= lat_cnt;
                    measuring <= 0;
                end
            end
            if (prev_sclk && !sclk_o) begin
                dout_m  <= (bit_idx < 12) ? m_word[11 - bit_idx] : 1'b0;
                bit_idx <= bit_idx + 1;
            end
        end else begin
            dout_m <= 1'b1;
            hi_cnt <= (!prev_cs) ? 1 : hi_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (valid_o) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0 && busy_o == 1'b0 && valid_o == 1'b0, "R1 sclk/busy/valid", {sclk_o, busy_o, valid_o}, 0);
        chk(aborted_o == 1'b0 && marker_err_o == 1'b0, "R1 flags", {aborted_o, marker_err_o}, 0);
    endtask

    task automatic t_normal(input logic [11:0] w, input int dly);
        bit got;
        m_word = w;
        m_delay = dly;
        pulse_start();
        chk(busy_o == 1'b1 && cs_n_o == 1'b0, "R2 start accepted", {busy_o, cs_n_o}, 2);
        wait_valid(got);
        chk(got, "R7 valid seen", got, 1);
        chk(result_o == w, "R7 result", result_o, w);
        chk(cs_n_o == 1'b1, "R7 cs high with valid", cs_n_o, 1);
        chk(rises == 13, "R6 sclk rises", rises, 13);
        chk(marker_err_o == 1'b0, "R8 marker ok", marker_err_o, 0);
        chk(aborted_o == 1'b0, "R10 aborted clear", aborted_o, 0);
        chk(first_lat >= dly && first_lat < dly + HALF + 10, "R4 waits for rise", first_lat, dly + HALF);
        @(negedge clk);
        chk(busy_o == 1'b1, "R12 busy in recovery", busy_o, 1);
        wait_idle();
    endtask

    task automatic t_timeout(input logic [11:0] w);
        bit got;
        m_word = w;
        m_delay = 0;
        pulse_start();
        wait_valid(got);
        chk(got, "R5 valid after timeout", got, 1);
        chk(first_lat >= TIMEOUT && first_lat < TIMEOUT + HALF + 10, "R5 timeout latency", first_lat, TIMEOUT + HALF);
        chk(result_o == w, "R5 result", result_o, w);
        chk(marker_err_o == 1'b1, "R8 marker zero flagged", marker_err_o, 1);
        wait_idle();
    endtask

    task automatic t_busy_start();
        bit got;
        int f0;
        f0 = frames;
        m_word = 12'h5A3;
        m_delay = 150;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        wait_valid(got);
        chk(result_o == 12'h5A3, "R2 result", result_o, 12'h5A3);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(frames == f0 + 1, "R2 start while busy ignored", frames - f0, 1);
        chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R12 idle after recovery", {cs_n_o, busy_o}, 2);
    endtask

    task automatic t_recover();
        bit got;
        m_word = 12'h0F1;
        m_delay = 80;
        pulse_start();
        wait_valid(got);
        start_i = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!cs_n_o) break;
        end
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(last_hi >= RECOVER && last_hi < ACQ, "R9 recovery interval", last_hi, RECOVER);
        wait_valid(got);
        chk(result_o == 12'h0F1, "R9 next frame result", result_o, 12'h0F1);
        wait_idle();
    endtask

    task automatic t_abort();
        bit got;
        int v0;
        v0 = valids;
        m_word = 12'hC3C;
        m_delay = 1000;
        pulse_start();
        repeat (60) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(cs_n_o == 1'b1, "R10 cs raised", cs_n_o, 1);
        chk(aborted_o == 1'b1, "R10 aborted set", aborted_o, 1);
        repeat (3) @(negedge clk);
        chk(rises == 0, "R10 no sclk", rises, 0);
        chk(valids == v0, "R10 no valid", valids - v0, 0);
        m_delay = 90;
        start_i = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!cs_n_o) break;
        end
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(last_hi >= ACQ, "R10 acquisition wait", last_hi, ACQ);
        wait_valid(got);
        chk(aborted_o == 1'b0, "R10 aborted cleared", aborted_o, 0);
        chk(result_o == 12'hC3C, "R10 result after abort", result_o, 12'hC3C);
        wait_idle();
    endtask

    task automatic t_abort_readout();
        bit got;
        m_word = 12'h9E7;
        m_delay = 100;
        pulse_start();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rises >= 3) break;
        end
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(cs_n_o == 1'b0, "R11 frame continues", cs_n_o, 0);
        wait_valid(got);
        chk(got && result_o == 12'h9E7, "R11 result", result_o, 12'h9E7);
        chk(aborted_o == 1'b0, "R11 not aborted", aborted_o, 0);
        chk(rises == 13, "R11 full readout", rises, 13);
        wait_idle();
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_normal(12'hA5C, 100);
        t_normal(12'hFFF, 40);
        t_normal(12'h001, 300);
        t_timeout(12'h6B2);
        t_normal(12'h800, 60);
        t_busy_start();
        t_recover();
        t_abort();
        t_abort_readout();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule